// File: doc/BRIEF.md
# Flash DMA Engine with Read Checksum

This block is the transfer engine of a flash memory controller. It moves 32-bit words between the flash mapping window and system DRAM. It reaches each side through its own bus master port. Software sets up a flash address, a DRAM address, a byte length and a mode through a small register port, then writes a go bit. The engine then reads one word, writes it to the other side and steps its pointers. It repeats this until the length reaches zero.

A second mode reads flash only and adds every word into a 32-bit running sum. Nothing is written to DRAM in this mode. Software reads flash at several read-timing settings and compares the sums to find a setting that returns correct data.

While a run is in progress, the pointer and length registers hold the current working values. If any access fails, the run stops and the failing step stays visible in those registers. Completion and failure are reported through two sticky flags.

Top module: `flashDmaEngine`

## Requirements
- R1: After reset every register reads zero and busy, done and error are low. Register offsets: 0 mode/go (bit0 go, bit1 toward-flash, bit2 sum mode; bits 1 and 2 read back), 1 flash pointer, 2 DRAM pointer, 3 length, 4 sum, 5 status (bit0 busy, bit1 done, bit2 error).
- R2: In copy mode with toward-flash clear, each word is read on the flash port and the same value is written on the DRAM port at the DRAM pointer.
- R3: In copy mode with toward-flash set, each word is read on the DRAM port and the same value is written on the flash port at the flash pointer.
- R4: In sum mode, each word read from flash is added into the sum register modulo 2^32. No DRAM access is made and the DRAM pointer does not change.
- R5: A go with both sum mode and toward-flash set makes no bus access, leaves pointers and length unchanged and sets the error flag.
- R6: Length bits 1:0 are stored as zero. The run ends when the length reaches zero. A go with zero length sets done at once without any bus access.
- R7: After each completed word the flash pointer rises by 4, the DRAM pointer rises by 4 (copy mode only) and the length falls by 4. Reads during a run return these live values.
- R8: An error response on either port ends the run at once. The error flag is set, done stays clear, and the pointers and length keep the values they had for the failing word.
- R9: While busy, writes to the mode/go, pointer, length and sum registers are ignored.
- R10: Done and error are sticky and are cleared by writing one to their status bit. A completion in the same cycle as a clear leaves the flag set.
- R11: Each port has at most one access outstanding. Only one port requests at a time. A request holds its address and kind until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| busy | output | 1 | Run in progress |
| doneFlag | output | 1 | Sticky completion flag |
| errFlag | output | 1 | Sticky error flag |
| flashReqValid | output | 1 | Flash port request valid |
| flashReqReady | input | 1 | Flash port accepts request |
| flashReqWrite | output | 1 | Flash request is a write |
| flashReqAddr | output | 32 | Flash request byte address |
| flashReqWdata | output | 32 | Flash write data, byte 0 in bits 7:0 |
| flashRspValid | input | 1 | Flash response valid |
| flashRspData | input | 32 | Flash read data, byte 0 in bits 7:0 |
| flashRspErr | input | 1 | Flash response error |
| dramReqValid | output | 1 | DRAM port request valid |
| dramReqReady | input | 1 | DRAM port accepts request |
| dramReqWrite | output | 1 | DRAM request is a write |
| dramReqAddr | output | 32 | DRAM request byte address |
| dramReqWdata | output | 32 | DRAM write data |
| dramRspValid | input | 1 | DRAM response valid |
| dramRspData | input | 32 | DRAM read data |
| dramRspErr | input | 1 | DRAM response error |

## Verification
The final response of a run can arrive in the same cycle as a software write that clears the done bit. The bench provokes this from its flash responder: the response for the last sum-mode word and the status write are driven at the same edge. Done must still be set afterwards, and a later plain clear must drop it. A second overlap is a go or pointer write that lands while a slow run is busy. It is judged by the scoreboard of DRAM writes and by the final register values.

// File: rtl/fdmaPkg.sv
package fdmaPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_RSP,
    ST_WR_REQ,
    ST_WR_RSP
  } dmaState_t;

  // Strobes from the sequencer into the datapath
  typedef struct packed {
    logic loadData;
    logic stepFlash;
    logic stepDram;
    logic stepLen;
    logic addSum;
  } dpStrobe_t;

  localparam logic [2:0] REG_MODE   = 3'd0;
  localparam logic [2:0] REG_FPTR   = 3'd1;
  localparam logic [2:0] REG_DPTR   = 3'd2;
  localparam logic [2:0] REG_LEN    = 3'd3;
  localparam logic [2:0] REG_SUM    = 3'd4;
  localparam logic [2:0] REG_STATUS = 3'd5;

  localparam int BIT_GO   = 0;
  localparam int BIT_DIR  = 1;
  localparam int BIT_SUM  = 2;
  localparam int BIT_DONE = 1;
  localparam int BIT_ERR  = 2;

endpackage

// File: rtl/fdmaDatapath.sv
module fdmaDatapath
  import fdmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cfgLock,
  input  dpStrobe_t         strobe,
  input  logic              srcIsDram,
  input  logic [DATA_W-1:0] flashRspData,
  input  logic [DATA_W-1:0] dramRspData,
  output logic [ADDR_W-1:0] flashPtr,
  output logic [ADDR_W-1:0] dramPtr,
  output logic [ADDR_W-1:0] xferLen,
  output logic [DATA_W-1:0] sumAcc,
  output logic [DATA_W-1:0] dataBuf,
  output logic              lenZero,
  output logic              lenLast
);

  localparam int STEP_BYTES = DATA_W / 8;
  localparam int LSB_W      = $clog2(STEP_BYTES);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP_BYTES);

  logic cfgWr;
  assign cfgWr = regWrEn && !cfgLock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flashPtr <= '0;
      dramPtr  <= '0;
      xferLen  <= '0;
      sumAcc   <= '0;
      dataBuf  <= '0;
    end else begin
      if (cfgWr) begin
        case (regAddr)
          REG_FPTR: flashPtr <= regWrData[ADDR_W-1:0];
          REG_DPTR: dramPtr  <= regWrData[ADDR_W-1:0];
          REG_LEN:  xferLen  <= {regWrData[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
          REG_SUM:  sumAcc   <= regWrData;
          default: ;
        endcase
      end
      if (strobe.loadData)  dataBuf  <= srcIsDram ? dramRspData : flashRspData;
      if (strobe.addSum)    sumAcc   <= sumAcc + flashRspData;
      if (strobe.stepFlash) flashPtr <= flashPtr + STEP_A;
      if (strobe.stepDram)  dramPtr  <= dramPtr + STEP_A;
      if (strobe.stepLen)   xferLen  <= xferLen - STEP_A;
    end
  end

  assign lenZero = (xferLen == '0);
  assign lenLast = (xferLen == STEP_A);

endmodule

// File: rtl/fdmaCtrl.sv
module fdmaCtrl
  import fdmaPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic [2:0] regAddr,
  input  logic [2:0] regWrBits,
  input  logic      lenZero,
  input  logic      lenLast,
  input  logic      flashReqReady,
  input  logic      flashRspValid,
  input  logic      flashRspErr,
  input  logic      dramReqReady,
  input  logic      dramRspValid,
  input  logic      dramRspErr,
  output logic      flashReqValid,
  output logic      flashReqWrite,
  output logic      dramReqValid,
  output logic      dramReqWrite,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      doneFlag,
  output logic      errFlag,
  output logic      toFlash,
  output logic      sumMode
);

  dmaState_t state, nextState;
  logic modeWr, statWr, goReq, badMode;
  logic srcReady, srcRspValid, srcRspErr;
  logic dstReady, dstRspValid, dstRspErr;
  logic doneSet, errSet, readPhase, writePhase;

  assign modeWr  = regWrEn && (regAddr == REG_MODE);
  assign statWr  = regWrEn && (regAddr == REG_STATUS);
  assign goReq   = modeWr && regWrBits[BIT_GO] && (state == ST_IDLE);
  assign badMode = regWrBits[BIT_SUM] && regWrBits[BIT_DIR];

  // Source is DRAM when moving toward flash; destination is the other side
  assign srcReady    = toFlash ? dramReqReady  : flashReqReady;
  assign srcRspValid = toFlash ? dramRspValid  : flashRspValid;
  assign srcRspErr   = toFlash ? dramRspErr    : flashRspErr;
  assign dstReady    = toFlash ? flashReqReady : dramReqReady;
  assign dstRspValid = toFlash ? flashRspValid : dramRspValid;
  assign dstRspErr   = toFlash ? flashRspErr   : dramRspErr;

  always_comb begin
    nextState = state;
    strobe    = '0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (goReq) begin
          if (badMode)      errSet    = 1'b1;
          else if (lenZero) doneSet   = 1'b1;
          else              nextState = ST_RD_REQ;
        end
      end
      ST_RD_REQ: if (srcReady) nextState = ST_RD_RSP;
      ST_RD_RSP: begin
        if (srcRspValid) begin
          if (srcRspErr) begin
            errSet    = 1'b1;
            nextState = ST_IDLE;
          end else if (sumMode) begin
            strobe.addSum    = 1'b1;
            strobe.stepFlash = 1'b1;
            strobe.stepLen   = 1'b1;
            if (lenLast) begin
              doneSet   = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_RD_REQ;
            end
          end else begin
            strobe.loadData = 1'b1;
            nextState       = ST_WR_REQ;
          end
        end
      end
      ST_WR_REQ: if (dstReady) nextState = ST_WR_RSP;
      ST_WR_RSP: begin
        if (dstRspValid) begin
          if (dstRspErr) begin
            errSet    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strobe.stepFlash = 1'b1;
            strobe.stepDram  = 1'b1;
            strobe.stepLen   = 1'b1;
            if (lenLast) begin
              doneSet   = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_RD_REQ;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      toFlash  <= 1'b0;
      sumMode  <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      state <= nextState;
      if (modeWr && state == ST_IDLE) begin
        toFlash <= regWrBits[BIT_DIR];
        sumMode <= regWrBits[BIT_SUM];
      end
      // A set in the same cycle as a clear wins
      doneFlag <= doneSet | (doneFlag & ~(statWr & regWrBits[BIT_DONE]));
      errFlag  <= errSet  | (errFlag  & ~(statWr & regWrBits[BIT_ERR]));
    end
  end

  assign busy       = (state != ST_IDLE);
  assign readPhase  = (state == ST_RD_REQ);
  assign writePhase = (state == ST_WR_REQ);

  assign flashReqValid = (readPhase && !toFlash) || (writePhase && toFlash);
  assign dramReqValid  = (readPhase && toFlash) || (writePhase && !toFlash);
  assign flashReqWrite = writePhase;
  assign dramReqWrite  = writePhase;

  p_one_master_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(flashReqValid && dramReqValid));

  p_sum_no_dram_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sumMode) |-> !dramReqValid);

  p_no_bad_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(sumMode && toFlash));

  p_err_ends_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy);

endmodule

// File: rtl/flashDmaEngine.sv
module flashDmaEngine
  import fdmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              busy,
  output logic              doneFlag,
  output logic              errFlag,
  output logic              flashReqValid,
  input  logic              flashReqReady,
  output logic              flashReqWrite,
  output logic [ADDR_W-1:0] flashReqAddr,
  output logic [DATA_W-1:0] flashReqWdata,
  input  logic              flashRspValid,
  input  logic [DATA_W-1:0] flashRspData,
  input  logic              flashRspErr,
  output logic              dramReqValid,
  input  logic              dramReqReady,
  output logic              dramReqWrite,
  output logic [ADDR_W-1:0] dramReqAddr,
  output logic [DATA_W-1:0] dramReqWdata,
  input  logic              dramRspValid,
  input  logic [DATA_W-1:0] dramRspData,
  input  logic              dramRspErr
);

  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(DATA_W / 8);

  dpStrobe_t         strobe;
  logic              toFlash, sumMode, lenZero, lenLast;
  logic [ADDR_W-1:0] flashPtr, dramPtr, xferLen;
  logic [DATA_W-1:0] sumAcc, dataBuf;

  fdmaCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrBits(regWrData[2:0]),
    .lenZero(lenZero), .lenLast(lenLast),
    .flashReqReady(flashReqReady), .flashRspValid(flashRspValid), .flashRspErr(flashRspErr),
    .dramReqReady(dramReqReady), .dramRspValid(dramRspValid), .dramRspErr(dramRspErr),
    .flashReqValid(flashReqValid), .flashReqWrite(flashReqWrite),
    .dramReqValid(dramReqValid), .dramReqWrite(dramReqWrite),
    .strobe(strobe), .busy(busy), .doneFlag(doneFlag), .errFlag(errFlag),
    .toFlash(toFlash), .sumMode(sumMode)
  );

  fdmaDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .cfgLock(busy), .strobe(strobe), .srcIsDram(toFlash),
    .flashRspData(flashRspData), .dramRspData(dramRspData),
    .flashPtr(flashPtr), .dramPtr(dramPtr), .xferLen(xferLen),
    .sumAcc(sumAcc), .dataBuf(dataBuf),
    .lenZero(lenZero), .lenLast(lenLast)
  );

  assign flashReqAddr  = flashPtr;
  assign dramReqAddr   = dramPtr;
  assign flashReqWdata = dataBuf;
  assign dramReqWdata  = dataBuf;

  always_comb begin
    case (regAddr)
      REG_MODE:   regRdData = DATA_W'({sumMode, toFlash, 1'b0});
      REG_FPTR:   regRdData = DATA_W'(flashPtr);
      REG_DPTR:   regRdData = DATA_W'(dramPtr);
      REG_LEN:    regRdData = DATA_W'(xferLen);
      REG_SUM:    regRdData = sumAcc;
      REG_STATUS: regRdData = DATA_W'({errFlag, doneFlag, busy});
      default:    regRdData = '0;
    endcase
  end

  p_hold_flash_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flashReqValid && !flashReqReady) |=>
      (flashReqValid && $stable(flashReqAddr) && $stable(flashReqWrite)));

  p_hold_dram_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dramReqValid && !dramReqReady) |=>
      (dramReqValid && $stable(dramReqAddr) && $stable(dramReqWrite)));

  p_len_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && xferLen != $past(xferLen)) |->
      (xferLen == $past(xferLen) - STEP_A));

endmodule

// File: tb/tb_flashDmaEngine.sv
`timescale 1ns/1ps
module tb_flashDmaEngine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        drvWrEn = 1'b0;
  logic [2:0]  drvAddr = '0;
  logic [31:0] drvData = '0;
  logic        collideNow = 1'b0;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic busy, doneFlag, errFlag;
  logic flashReqValid, flashReqReady, flashReqWrite, flashRspValid, flashRspErr;
  logic dramReqValid, dramReqReady, dramReqWrite, dramRspValid, dramRspErr;
  logic [31:0] flashReqAddr, flashReqWdata, flashRspData;
  logic [31:0] dramReqAddr, dramReqWdata, dramRspData;

  assign regWrEn   = collideNow ? 1'b1 : drvWrEn;
  assign regAddr   = collideNow ? 3'd5 : drvAddr;
  assign regWrData = collideNow ? 32'h2 : drvData;

  flashDmaEngine dut (.*);

  logic [31:0] flashMem [64];
  logic [31:0] dramMem  [64];
  logic [31:0] expAddrQ [$];
  logic [31:0] expDataQ [$];
  int checks = 0, errors = 0;
  int flashReqCnt = 0, dramReqCnt = 0;
  int flashLat = 0, dramLat = 0;
  bit stallOn = 0, flashErrOn = 0, collideArm = 0, finished = 0;
  logic [31:0] flashErrAddr = '0, collideAddr = '0;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    drvWrEn = 1'b1; drvAddr = a; drvData = d;
    @(negedge clk);
    drvWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    drvAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 5000);
    chkEq("R6 run ends", {31'b0, busy}, 32'h0);
  endtask

  task automatic sbWrite(input string req, input logic [31:0] a, input logic [31:0] d);
    if (expAddrQ.size() == 0) begin
      chkEq({req, " unexpected write"}, a, 32'hFFFF_FFFF);
    end else begin
      chkEq({req, " write addr"}, a, expAddrQ.pop_front());
      chkEq({req, " write data"}, d, expDataQ.pop_front());
    end
  endtask

  // Ready toggling between edges
  initial begin
    flashReqReady = 1'b1; dramReqReady = 1'b1;
    forever begin
      @(posedge clk); #1;
      flashReqReady = stallOn ? ~flashReqReady : 1'b1;
      dramReqReady  = stallOn ? ~dramReqReady  : 1'b1;
    end
  end

  // Flash responder and write monitor
  initial begin
    flashRspValid = 1'b0; flashRspErr = 1'b0; flashRspData = '0;
    @(negedge clk);
    forever begin
      if (flashReqValid && flashReqReady) begin
        logic [31:0] a, d; logic w, hit, col;
        a = flashReqAddr; d = flashReqWdata; w = flashReqWrite;
        hit = flashErrOn && (a == flashErrAddr);
        col = collideArm && (a == collideAddr);
        flashReqCnt++;
        if (w) begin
          sbWrite("R3", a, d);
          if (!hit) flashMem[a[7:2]] = d;
        end
        repeat (flashLat + 1) @(negedge clk);
        flashRspValid = 1'b1; flashRspErr = hit;
        flashRspData = w ? 32'h0 : flashMem[a[7:2]];
        if (col) collideNow = 1'b1;
        @(negedge clk);
        flashRspValid = 1'b0; flashRspErr = 1'b0; collideNow = 1'b0;
        if (col) collideArm = 0;
      end else @(negedge clk);
    end
  end

  // DRAM responder and write monitor
  initial begin
    dramRspValid = 1'b0; dramRspErr = 1'b0; dramRspData = '0;
    @(negedge clk);
    forever begin
      if (dramReqValid && dramReqReady) begin
        logic [31:0] a, d; logic w;
        a = dramReqAddr; d = dramReqWdata; w = dramReqWrite;
        dramReqCnt++;
        if (w) begin
          sbWrite("R2", a, d);
          dramMem[a[7:2]] = d;
        end
        repeat (dramLat + 1) @(negedge clk);
        dramRspValid = 1'b1;
        dramRspData = w ? 32'h0 : dramMem[a[7:2]];
        @(negedge clk);
        dramRspValid = 1'b0;
      end else @(negedge clk);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R6 watchdog actual=busy expected=idle");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, expSum;
    int fBase, dBase;
    for (int i = 0; i < 64; i++) begin
      flashMem[i] = 32'hF123_4567 + i * 32'h0BAD_CAFE;
      dramMem[i]  = 32'h5A5A_0000 ^ (i * 32'h0001_0203);
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int r = 0; r < 6; r++) begin
      regRead(3'(r), rd);
      chkEq("R1 reset register", rd, 32'h0);
    end
    chkEq("R1 flags", {29'b0, busy, doneFlag, errFlag}, 32'h0);

    // R2 flash to DRAM, with wait states and ready stalls
    flashLat = 1; dramLat = 2; stallOn = 1;
    regWrite(3'd1, 32'h10); regWrite(3'd2, 32'h40); regWrite(3'd3, 32'd16);
    for (int i = 0; i < 4; i++) begin
      expAddrQ.push_back(32'h40 + 4 * i); expDataQ.push_back(flashMem[4 + i]);
    end
    regWrite(3'd0, 32'h1);
    waitIdle();
    stallOn = 0;
    chkEq("R2 done", {30'b0, doneFlag, errFlag}, 32'h2);
    chkEq("R2 scoreboard drained", expAddrQ.size(), 0);
    regRead(3'd1, rd); chkEq("R7 final flash ptr", rd, 32'h20);
    regRead(3'd2, rd); chkEq("R7 final dram ptr", rd, 32'h50);
    regRead(3'd3, rd); chkEq("R6 final length", rd, 32'h0);
    regWrite(3'd5, 32'h6);
    chkEq("R10 done cleared", {31'b0, doneFlag}, 32'h0);

    // R3 DRAM to flash, R6 length low bits dropped
    flashLat = 0; dramLat = 1;
    regWrite(3'd1, 32'h0); regWrite(3'd2, 32'h80); regWrite(3'd3, 32'hB);
    regRead(3'd3, rd); chkEq("R6 length low bits", rd, 32'h8);
    for (int i = 0; i < 2; i++) begin
      expAddrQ.push_back(32'h0 + 4 * i); expDataQ.push_back(dramMem[32 + i]);
    end
    regWrite(3'd0, 32'h3);
    waitIdle();
    chkEq("R3 done", {30'b0, doneFlag, errFlag}, 32'h2);
    chkEq("R3 scoreboard drained", expAddrQ.size(), 0);
    chkEq("R3 flash word", flashMem[1], dramMem[33]);
    regRead(3'd0, rd); chkEq("R1 mode readback", rd, 32'h2);
    regWrite(3'd5, 32'h6);

    // R4 sum mode, accumulates and wraps
    regWrite(3'd4, 32'h0); regWrite(3'd1, 32'h40); regWrite(3'd2, 32'h120);
    regWrite(3'd3, 32'd16);
    expSum = 32'h0;
    for (int i = 16; i < 20; i++) expSum = expSum + flashMem[i];
    dBase = dramReqCnt;
    regWrite(3'd0, 32'h5);
    waitIdle();
    regRead(3'd4, rd); chkEq("R4 sum", rd, expSum);
    chkEq("R4 no dram access", dramReqCnt - dBase, 0);
    regRead(3'd2, rd); chkEq("R4 dram ptr kept", rd, 32'h120);
    regRead(3'd1, rd); chkEq("R7 sum flash ptr", rd, 32'h50);
    regWrite(3'd3, 32'd8);
    expSum = expSum + flashMem[20] + flashMem[21];
    regWrite(3'd0, 32'h5);
    waitIdle();
    regRead(3'd4, rd); chkEq("R4 sum continues modulo", rd, expSum);
    regWrite(3'd5, 32'h6);

    // R5 rejected sum toward flash
    regWrite(3'd3, 32'd8);
    fBase = flashReqCnt; dBase = dramReqCnt;
    regWrite(3'd0, 32'h7);
    repeat (3) @(negedge clk);
    chkEq("R5 error flag", {29'b0, busy, doneFlag, errFlag}, 32'h1);
    chkEq("R5 no access", (flashReqCnt - fBase) + (dramReqCnt - dBase), 0);
    regRead(3'd3, rd); chkEq("R5 length kept", rd, 32'h8);
    regWrite(3'd5, 32'h4);
    chkEq("R10 error cleared", {31'b0, errFlag}, 32'h0);

    // R6 zero length
    regWrite(3'd3, 32'h0);
    fBase = flashReqCnt;
    regWrite(3'd0, 32'h1);
    chkEq("R6 zero length done", {29'b0, busy, doneFlag, errFlag}, 32'h2);
    chkEq("R6 zero length no access", flashReqCnt - fBase, 0);
    regWrite(3'd5, 32'h6);

    // R7 live values, R9 writes while busy ignored
    flashLat = 6; dramLat = 0;
    regWrite(3'd1, 32'h0); regWrite(3'd2, 32'hC0); regWrite(3'd3, 32'd12);
    for (int i = 0; i < 3; i++) begin
      expAddrQ.push_back(32'hC0 + 4 * i); expDataQ.push_back(flashMem[i]);
    end
    fBase = flashReqCnt;
    regWrite(3'd0, 32'h1);
    wait (flashReqCnt == fBase + 2);
    regRead(3'd1, rd); chkEq("R7 live flash ptr", rd, 32'h4);
    regRead(3'd2, rd); chkEq("R7 live dram ptr", rd, 32'hC4);
    regRead(3'd3, rd); chkEq("R7 live length", rd, 32'h8);
    regWrite(3'd0, 32'h5);
    regWrite(3'd1, 32'h80);
    regWrite(3'd4, 32'h1234);
    waitIdle();
    chkEq("R9 scoreboard drained", expAddrQ.size(), 0);
    regRead(3'd1, rd); chkEq("R9 flash ptr not overwritten", rd, 32'hC);
    regRead(3'd0, rd); chkEq("R9 mode not overwritten", rd, 32'h0);
    regRead(3'd4, rd); chkEq("R9 sum not overwritten", rd, expSum);
    regWrite(3'd5, 32'h6);

    // R8 error abort on third flash read
    flashLat = 0; dramLat = 1; flashErrOn = 1; flashErrAddr = 32'h28;
    regWrite(3'd1, 32'h20); regWrite(3'd2, 32'h0); regWrite(3'd3, 32'd16);
    for (int i = 0; i < 2; i++) begin
      expAddrQ.push_back(32'h0 + 4 * i); expDataQ.push_back(flashMem[8 + i]);
    end
    fBase = flashReqCnt;
    regWrite(3'd0, 32'h1);
    waitIdle();
    repeat (4) @(negedge clk);
    flashErrOn = 0;
    chkEq("R8 flags", {30'b0, doneFlag, errFlag}, 32'h1);
    chkEq("R8 scoreboard drained", expAddrQ.size(), 0);
    chkEq("R8 reads stop", flashReqCnt - fBase, 3);
    regRead(3'd1, rd); chkEq("R8 flash ptr at failing word", rd, 32'h28);
    regRead(3'd2, rd); chkEq("R8 dram ptr at failing word", rd, 32'h8);
    regRead(3'd3, rd); chkEq("R8 length at failing word", rd, 32'h8);
    regWrite(3'd5, 32'h6);

    // R10 completion and clear in the same cycle
    regWrite(3'd4, 32'h0); regWrite(3'd1, 32'h0); regWrite(3'd3, 32'd8);
    collideAddr = 32'h4; collideArm = 1;
    regWrite(3'd0, 32'h5);
    waitIdle();
    repeat (2) @(negedge clk);
    chkEq("R10 set wins over clear", {31'b0, doneFlag}, 32'h1);
    chkEq("R10 collision happened", {31'b0, collideArm}, 32'h0);
    regWrite(3'd5, 32'h2);
    chkEq("R10 later clear", {31'b0, doneFlag}, 32'h0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule